// File: doc/BRIEF.md
# Frame-Based Input Smoothing Switch

This block is a small cell switch with `N` input ports and `N` output ports. It does not switch cells one slot at a time. Each input instead holds the cells it receives over a frame of `B` consecutive time slots, where one clock cycle is one time slot. When a frame closes, every cell held by every input is offered at once to a crossbar that is `N*B` lanes wide on both sides. The cell that input `i` received in slot `s` of the frame uses fabric lane `i*B + s`.

Each output can take up to `B` cells from a single frame into its own output FIFO. It then sends them downstream one per cycle on a valid/ready handshake. Cells that exceed an output's per-frame limit, or that would overflow its FIFO, are discarded and added to a running drop count. The frame store is double-buffered, so the next frame fills without a gap while the previous one is switched. The block does not restore arrival order at an output.

Top module: `smooth_switch`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every `out_valid` bit is 0 and `drop_count` is 0. The slot counter restarts at slot 0 on the first clock edge after reset.
- R2: The slot of a clock edge is the number of edges since reset, modulo `B`. A cell sampled on input `i` at slot `s` takes fabric lane `i*B+s`. All cells of a frame are written into the output FIFOs on the clock edge that follows the frame's last slot edge, and they are visible on the outputs right after that edge.
- R3: Among the valid cells of one frame that carry the same destination, the ones on the lowest-numbered lanes are kept, at most `B` of them. They enter that output's FIFO in ascending lane order, and the remaining cells are dropped.
- R4: The number of cells an output accepts from a frame is also limited by its free FIFO space, which is `DEPTH` minus the occupancy before the launch edge, ignoring a pop on that same edge. Any cell beyond that space is dropped, again from the highest lanes. A FIFO never holds more than `DEPTH` cells.
- R5: `drop_count` grows by exactly the number of cells dropped at each launch, changes at no other time, and wraps at its width.
- R6: `out_valid[o]` is 1 exactly when output FIFO `o` is non-empty, and `out_data` slice `o` shows its oldest cell. A cell is removed only on a cycle with `out_ready[o]` high, at most one per cycle. While `out_ready[o]` is low, the head cell and its valid bit hold.
- R7: Frames follow one another with no idle slot. Cells arriving in the slots right after a frame closes are captured into the other buffer and are switched correctly in their own frame.
- R8: A lane whose valid bit was 0 when sampled produces no output cell and no drop, whatever its destination and payload bits hold.
- R9: The destination field of each input is an unsigned binary output index of `$clog2(N)` bits. Input `i` uses bits `[i*DESTW +: DESTW]` of `in_dest` and bits `[i*DW +: DW]` of `in_data`, and output `o` uses bits `[o*DW +: DW]` of `out_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one time slot |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N | Per-input cell present flag |
| in_dest | input | N*DESTW | Per-input destination output index |
| in_data | input | N*DW | Per-input cell payload |
| out_valid | output | N | Per-output cell available |
| out_ready | input | N | Per-output downstream accepts the head cell |
| out_data | output | N*DW | Per-output head cell payload |
| drop_count | output | DCW | Running count of discarded cells |

## Verification
The bench targets several specific mistakes. It sends frames where many lanes contend for one output. A design that ranked lanes in the wrong direction, or dropped from the wrong end, would deliver the wrong payloads there. It fills an output FIFO to one short of full and then offers two cells. A design that ignored free space would overflow and corrupt older cells, and one that ignored a partial fit would lose a cell it could have kept. Back-to-back frames expose a single-buffered store, which would overwrite a frame before it was switched. Frames with every valid bit low expose a design that looks at the destination without checking the valid bit.

// File: rtl/smooth_switch.sv
module smooth_switch #(
  parameter int N     = 4,
  parameter int B     = 2,
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int DCW   = 16,
  localparam int DESTW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     in_valid,
  input  logic [N*DESTW-1:0] in_dest,
  input  logic [N*DW-1:0]  in_data,
  output logic [N-1:0]     out_valid,
  input  logic [N-1:0]     out_ready,
  output logic [N*DW-1:0]  out_data,
  output logic [DCW-1:0]   drop_count
);
  localparam int LANES = N * B;
  localparam int SW    = (B > 1) ? $clog2(B) : 1;
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 1);

  // two frame buffers: one fills while the other is switched
  logic [1:0][LANES-1:0]            fb_v;
  logic [1:0][LANES-1:0][DESTW-1:0] fb_d;
  logic [1:0][LANES-1:0][DW-1:0]    fb_p;
  logic [SW-1:0] slot;
  logic          bank;
  logic          launch;
  wire           sb = ~bank;

  logic [N-1:0][DEPTH-1:0][DW-1:0] mem;
  logic [N-1:0][PW-1:0] wptr, rptr;
  logic [N-1:0][CW-1:0] occ;
  logic [N-1:0]         pop;

  logic [LANES-1:0]         keep;
  logic [LANES-1:0][PW-1:0] rank;
  logic [N-1:0][CW-1:0]     pushn;
  int                       dropn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot   <= '0;
      bank   <= 1'b0;
      launch <= 1'b0;
      fb_v   <= '0;
      fb_d   <= '0;
      fb_p   <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        fb_v[bank][i*B + int'(slot)] <= in_valid[i];
        fb_d[bank][i*B + int'(slot)] <= in_dest[i*DESTW +: DESTW];
        fb_p[bank][i*B + int'(slot)] <= in_data[i*DW +: DW];
      end
      if (int'(slot) == B - 1) begin
        slot   <= '0;
        bank   <= ~bank;
        launch <= 1'b1;
      end else begin
        slot   <= slot + 1'b1;
        launch <= 1'b0;
      end
    end
  end

  // crossbar arbitration: lowest lanes win, limited by B and free space
  always_comb begin
    int hits, lim;
    keep  = '0;
    rank  = '0;
    pushn = '0;
    dropn = 0;
    for (int o = 0; o < N; o++) begin
      hits = 0;
      lim  = DEPTH - int'(occ[o]);
      if (lim > B) lim = B;
      for (int l = 0; l < LANES; l++) begin
        if (launch && fb_v[sb][l] && int'(fb_d[sb][l]) == o) begin
          if (hits < lim) begin
            keep[l] = 1'b1;
            rank[l] = PW'(hits);
          end else begin
            dropn = dropn + 1;
          end
          hits = hits + 1;
        end
      end
      pushn[o] = CW'((hits < lim) ? hits : lim);
    end
  end

  assign pop = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr       <= '0;
      rptr       <= '0;
      occ        <= '0;
      drop_count <= '0;
    end else begin
      for (int o = 0; o < N; o++) begin
        occ[o]  <= occ[o] + pushn[o] - CW'(pop[o]);
        wptr[o] <= wptr[o] + PW'(pushn[o]);
        rptr[o] <= rptr[o] + PW'(pop[o]);
      end
      drop_count <= drop_count + DCW'(dropn);
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++)
      if (keep[l])
        mem[fb_d[sb][l]][wptr[fb_d[sb][l]] + rank[l]] <= fb_p[sb][l];
  end

  for (genvar o = 0; o < N; o++) begin : g_out
    assign out_valid[o]          = (occ[o] != '0);
    assign out_data[o*DW +: DW]  = mem[o][rptr[o]];
  end
endmodule

// File: rtl/smooth_switch_chk.sv
module smooth_switch_chk #(
  parameter int N     = 4,
  parameter int B     = 2,
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int DCW   = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int SW   = (B > 1) ? $clog2(B) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         out_valid,
  input logic [N-1:0]         out_ready,
  input logic [N*DW-1:0]      out_data,
  input logic [DCW-1:0]       drop_count,
  input logic                 launch,
  input logic [SW-1:0]        slot,
  input logic [N-1:0][CW-1:0] occ
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    $rose(rst_n) |-> (out_valid == '0 && drop_count == '0)); // R1

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot) < B); // R2

  AST_DROP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    DCW'(drop_count - $past(drop_count)) <= DCW'(N * B)); // R5

  AST_DROP_AT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> $past(launch)); // R5

  for (genvar o = 0; o < N; o++) begin : g_chk
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occ[o]) <= DEPTH); // R4

    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_ready[o]) |=>
        (out_valid[o] && $stable(out_data[o*DW +: DW]))); // R6
  end
endmodule

bind smooth_switch smooth_switch_chk #(
  .N(N), .B(B), .DW(DW), .DEPTH(DEPTH), .DCW(DCW)
) u_chk (.*);

// File: tb/smooth_switch_bench.sv
module smooth_switch_bench;
  localparam int N = 4, B = 2, DW = 8, DEPTH = 8, DCW = 16;
  localparam int DESTW = 2, LANES = N * B;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [N-1:0]         in_valid = '0;
  logic [N*DESTW-1:0]   in_dest = '0;
  logic [N*DW-1:0]      in_data = '0;
  logic [N-1:0]         out_valid;
  logic [N-1:0]         out_ready = '0;
  logic [N*DW-1:0]      out_data;
  logic [DCW-1:0]       drop_count;

  int tests = 0, fails = 0, phase = 0, exp_drops = 0;

  always #2.5 clk = ~clk;

  smooth_switch #(.N(N), .B(B), .DW(DW), .DEPTH(DEPTH), .DCW(DCW)) u_smooth_switch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .drop_count(drop_count));

  always @(posedge clk) phase <= !rst_n ? 0 : (phase == B - 1 ? 0 : phase + 1);

  // {valid mask, per-lane destinations (lane 0 at bit 0), expected drops}
  localparam logic [31:0] VEC [4] = '{
    {8'hFF, 16'hE4E4, 8'd0},
    {8'hFF, 16'hAAAA, 8'd6},
    {8'h05, 16'h0013, 8'd0},
    {8'hA8, 16'h5555, 8'd1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] vm, input logic [15:0] dst, input int tag);
    while (phase != 0) @(negedge clk);
    for (int s = 0; s < B; s++) begin
      for (int i = 0; i < N; i++) begin
        in_valid[i] = vm[i*B+s];
        in_dest[i*DESTW +: DESTW] = dst[(i*B+s)*2 +: 2];
        in_data[i*DW +: DW] = {5'(tag), 3'(i*B+s)};
      end
      @(negedge clk);
    end
    in_valid = '0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic drain(input int o, input int n, input logic [7:0] exp [16], input string req);
    for (int k = 0; k < n; k++) begin
      check(out_valid[o] === 1'b1, req, int'(out_valid[o]), 1);
      check(out_data[o*DW +: DW] === exp[k], req, int'(out_data[o*DW +: DW]), int'(exp[k]));
      out_ready[o] = 1'b1;
      @(negedge clk);
    end
    out_ready[o] = 1'b0;
    check(out_valid[o] === 1'b0, req, int'(out_valid[o]), 0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    logic [7:0] exp [16];
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == '0, "R1", int'(out_valid), 0);
    check(drop_count == '0, "R1", int'(drop_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == '0 && drop_count == '0, "R1", int'(out_valid), 0);

    // table walk: R2 lane mapping, R3 ranking, R9 field positions
    for (int v = 0; v < 4; v++) begin
      send_frame(VEC[v][31:24], VEC[v][23:8], v + 1);
      settle();
      exp_drops += int'(VEC[v][7:0]);
      check(int'(drop_count) == exp_drops, "R3", int'(drop_count), exp_drops);
      for (int o = 0; o < N; o++) begin
        int n;
        n = 0;
        for (int l = 0; l < LANES; l++)
          if (VEC[v][24+l] && int'(VEC[v][8+2*l +: 2]) == o && n < B) begin
            exp[n] = {5'(v + 1), 3'(l)};
            n++;
          end
        drain(o, n, exp, "R2");
      end
    end

    // R8: frame with no valid lanes yields nothing
    send_frame(8'h00, 16'h1B1B, 9);
    settle();
    check(out_valid == '0, "R8", int'(out_valid), 0);
    check(int'(drop_count) == exp_drops, "R8", int'(drop_count), exp_drops);

    // R7 + R4: back-to-back frames to output 0, filling to 7 then a partial fit
    send_frame(8'h03, 16'h0000, 10);
    send_frame(8'h03, 16'h0000, 11);
    send_frame(8'h03, 16'h0000, 12);
    send_frame(8'h01, 16'h0000, 13);
    send_frame(8'h03, 16'h0000, 14);
    settle();
    exp_drops += 1;
    check(int'(drop_count) == exp_drops, "R4", int'(drop_count), exp_drops);
    exp = '{default: 8'h00};
    exp[0] = {5'd10, 3'd0}; exp[1] = {5'd10, 3'd1};
    exp[2] = {5'd11, 3'd0}; exp[3] = {5'd11, 3'd1};
    exp[4] = {5'd12, 3'd0}; exp[5] = {5'd12, 3'd1};
    exp[6] = {5'd13, 3'd0}; exp[7] = {5'd14, 3'd0};
    drain(0, 8, exp, "R7");

    // R4: full FIFO drops the whole frame
    for (int f = 0; f < 4; f++) send_frame(8'h03, 16'h0000, 16 + f);
    send_frame(8'h03, 16'h0000, 20);
    settle();
    exp_drops += 2;
    check(int'(drop_count) == exp_drops, "R4", int'(drop_count), exp_drops);
    // R6: head holds while not ready
    repeat (3) @(negedge clk);
    check(out_data[0 +: DW] === {5'd16, 3'd0}, "R6", int'(out_data[0 +: DW]), int'({5'd16, 3'd0}));
    for (int k = 0; k < 8; k++) exp[k] = {5'(16 + k / 2), 3'(k % 2)};
    drain(0, 8, exp, "R6");
    // R5: no spurious drop change over idle time
    repeat (6) @(negedge clk);
    check(int'(drop_count) == exp_drops, "R5", int'(drop_count), exp_drops);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule